// File: doc/BRIEF.md
# Integer Execute Stage with Condition Codes

This block is the execute step of a simple load/store integer pipeline. Each cycle in which `valid_i` is high, it takes a first operand and a second operand and applies the selected operation. The first operand always comes from a register. The second operand is either a register value or a sign-extended short immediate. The operations are add and subtract, including forms that use the held carry or borrow, reverse-operand subtraction, bitwise logic, shifts by any amount, and loading an upper immediate.

The result is captured in a destination register at the clock edge that ends the execute cycle. It is presented for write-back during the following cycle, and `wb_valid_o` marks that cycle. Four condition flags are updated only when the instruction asks for it; otherwise they keep their values.

In parallel, and with no clock in the path, the block outputs the sum of the first operand and the selected second operand. This sum serves as the effective address for loads, stores and indexed jumps. Decode, memory access and the register file sit outside the block.

Top module: `exu_stage`

## Requirements
- R1: Operation code 0 gives the sum of the two operands. Code 1 gives the sum plus the held C flag. For both, C is the carry out of bit 31, and V is set when the two operands have the same sign and the result has the other sign.
- R2: Code 2 gives first operand minus second operand. Code 3 also subtracts the held C flag, read as a borrow. For both, C is 1 exactly when a borrow out of bit 31 occurs, and V is set when the operands differ in sign and the result sign differs from the first operand.
- R3: Codes 4 and 5 match codes 2 and 3 with the operands swapped, so they give second operand minus first operand, and code 5 also subtracts the borrow. C and V follow the R2 rules applied to the swapped pair.
- R4: Codes 6, 7 and 8 give bitwise AND, OR and XOR. When these update the flags, V and C are cleared.
- R5: Codes 9, 10 and 11 shift the first operand left, right with zero fill, and right with copies of bit 31. The shift amount is the low 5 bits of the second operand, and the higher bits of the second operand are ignored. V and C are cleared.
- R6: Code 12 gives the 19-bit upper immediate in bits 31:13 and zeros in bits 12:0. Codes 13 to 15 give zero. V and C are cleared for all of these codes.
- R7: With `imm_sel_i` high, the second operand is the 13-bit immediate sign-extended to 32 bits, so bit 12 is copied into bits 31:13. With `imm_sel_i` low, the second operand is `s2_reg_i`.
- R8: The flag outputs are laid out as `flags_o` = {N, Z, V, C}, with N in bit 3. After an instruction with `setcc_i` high, N equals bit 31 of the new result and Z is 1 exactly when the new result is zero.
- R9: After a cycle in which `valid_i` or `setcc_i` is low, all four flags keep their previous values.
- R10: The result appears on `result_o` after the clock edge that ends the execute cycle, and `wb_valid_o` is high for the cycle that follows. After a cycle with `valid_i` low, `result_o` is unchanged and `wb_valid_o` is low.
- R11: `ea_o` always equals `rs_i` plus the selected second operand, modulo 2^32. It does not depend on the clock.
- R12: While reset is asserted, `result_o`, `flags_o` and `wb_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction executes this cycle |
| op_i | input | 4 | Operation code (see R1 to R6) |
| rs_i | input | 32 | First operand |
| s2_reg_i | input | 32 | Register value for the second operand |
| imm_sel_i | input | 1 | Selects the immediate as the second operand |
| imm_i | input | 13 | Short immediate, sign-extended |
| hi_imm_i | input | 19 | Upper immediate for code 12 |
| setcc_i | input | 1 | Update the flags with this instruction |
| ea_o | output | 32 | Base plus offset address |
| result_o | output | 32 | Destination register |
| wb_valid_o | output | 1 | The destination register holds a new result |
| flags_o | output | 4 | Condition flags {N, Z, V, C} |

## Verification
Every operation code is applied to every pair drawn from a set of corner operands: zero, one, the two signed extremes, all ones and half-word masks. These pairs separate carry from overflow and borrow from sign. Because the held carry changes from one instruction to the next, the carry and borrow forms are exercised with both values of the incoming flag. The shifts cover all 64 values of the six low amount bits, through both the register and the immediate path, which shows that only five bits take effect. Immediate values on both sides of the bit-12 sign boundary check sign extension. Runs with the flag update off, and idle cycles, check that the flags and the result are held.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_RSUB  = 4'd4,
    OP_RSUBC = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_SHL   = 4'd9,
    OP_SHR   = 4'd10,
    OP_SHA   = 4'd11,
    OP_UPIMM = 4'd12
  } op_e;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;
  localparam int FL_W = 4;

  typedef enum logic [1:0] {
    SEL_ARITH = 2'd0,
    SEL_LOGIC = 2'd1,
    SEL_SHIFT = 2'd2,
    SEL_CONST = 2'd3
  } unit_e;
endpackage

// File: rtl/exu_rst_sync.sv
module exu_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic [W-1:0]     reg_val_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             imm_sel_i,
  output logic [W-1:0]     opnd_o
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    opnd_o  = imm_sel_i ? imm_ext : reg_val_i;
  end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         swap_i,
  input  logic         sub_i,
  input  logic         use_flag_i,
  input  logic         c_flag_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic [W-1:0] y_eff;
  logic         cin;
  logic [W:0]   total;

  always_comb begin
    x_op  = swap_i ? b_i : a_i;
    y_op  = swap_i ? a_i : b_i;
    y_eff = sub_i ? ~y_op : y_op;
    if (sub_i) begin
      cin = use_flag_i ? ~c_flag_i : 1'b1;
    end else begin
      cin = use_flag_i ? c_flag_i : 1'b0;
    end
    total = {1'b0, x_op} + {1'b0, y_eff} + {{W{1'b0}}, cin};
    sum_o = total[W-1:0];
    c_o   = sub_i ? ~total[W] : total[W];
    v_o   = (x_op[W-1] == y_eff[W-1]) && (total[W-1] != x_op[W-1]);
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0]   data_rev;
  logic [W-1:0]   src;
  logic [W-1:0]   shr;
  logic [W-1:0]   shr_rev;
  logic [2*W-1:0] ext;
  logic           fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_rev[i] = data_i[W-1-i];
    assign shr_rev[i]  = shr[W-1-i];
  end

  always_comb begin
    src    = left_i ? data_rev : data_i;
    fill   = arith_i & ~left_i & data_i[W-1];
    ext    = {{W{fill}}, src};
    shr    = W'(ext >> amt_i);
    data_o = left_i ? shr_rev : shr;
  end
endmodule

// File: rtl/exu_stage.sv
module exu_stage #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [exu_pkg::OP_W-1:0] op_i,
  input  logic [W-1:0]            rs_i,
  input  logic [W-1:0]            s2_reg_i,
  input  logic                    imm_sel_i,
  input  logic [IMM_W-1:0]        imm_i,
  input  logic [W-IMM_W-1:0]      hi_imm_i,
  input  logic                    setcc_i,
  output logic [W-1:0]            ea_o,
  output logic [W-1:0]            result_o,
  output logic                    wb_valid_o,
  output logic [exu_pkg::FL_W-1:0] flags_o
);
  import exu_pkg::*;

  localparam int SH_W = $clog2(W);
  localparam int HI_W = W - IMM_W;

  logic             rst_n_int;
  logic [W-1:0]     s2;
  logic [W-1:0]     arith_res;
  logic             arith_c;
  logic             arith_v;
  logic [W-1:0]     shift_res;
  logic             swap;
  logic             is_sub;
  logic             use_flag;
  logic             sh_left;
  logic             sh_arith;
  unit_e            unit_sel;
  logic [W-1:0]     logic_res;
  logic [W-1:0]     exec_res;
  logic [FL_W-1:0]  new_flags;
  logic [W-1:0]     dst_d, dst_q;
  logic [FL_W-1:0]  fl_d, fl_q;
  logic             wbv_d, wbv_q;
  logic             fl_en;

  exu_rst_sync i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  exu_operand_sel #(.W(W), .IMM_W(IMM_W)) i_opsel (
    .reg_val_i (s2_reg_i),
    .imm_i     (imm_i),
    .imm_sel_i (imm_sel_i),
    .opnd_o    (s2)
  );

  // Decode of the operation code into unit controls
  always_comb begin
    swap     = 1'b0;
    is_sub   = 1'b0;
    use_flag = 1'b0;
    sh_left  = 1'b0;
    sh_arith = 1'b0;
    unit_sel = SEL_CONST;
    unique case (op_i)
      OP_ADD:   unit_sel = SEL_ARITH;
      OP_ADDC:  begin unit_sel = SEL_ARITH; use_flag = 1'b1; end
      OP_SUB:   begin unit_sel = SEL_ARITH; is_sub = 1'b1; end
      OP_SUBC:  begin unit_sel = SEL_ARITH; is_sub = 1'b1; use_flag = 1'b1; end
      OP_RSUB:  begin unit_sel = SEL_ARITH; is_sub = 1'b1; swap = 1'b1; end
      OP_RSUBC: begin
        unit_sel = SEL_ARITH; is_sub = 1'b1; swap = 1'b1; use_flag = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: unit_sel = SEL_LOGIC;
      OP_SHL:   begin unit_sel = SEL_SHIFT; sh_left = 1'b1; end
      OP_SHR:   unit_sel = SEL_SHIFT;
      OP_SHA:   begin unit_sel = SEL_SHIFT; sh_arith = 1'b1; end
      default:  unit_sel = SEL_CONST;
    endcase
  end

  exu_addsub #(.W(W)) i_addsub (
    .a_i        (rs_i),
    .b_i        (s2),
    .swap_i     (swap),
    .sub_i      (is_sub),
    .use_flag_i (use_flag),
    .c_flag_i   (fl_q[FL_C]),
    .sum_o      (arith_res),
    .c_o        (arith_c),
    .v_o        (arith_v)
  );

  exu_shifter #(.W(W), .SH_W(SH_W)) i_shifter (
    .data_i  (rs_i),
    .amt_i   (s2[SH_W-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .data_o  (shift_res)
  );

  // Logic unit and result selection
  always_comb begin
    case (op_i)
      OP_AND:  logic_res = rs_i & s2;
      OP_OR:   logic_res = rs_i | s2;
      default: logic_res = rs_i ^ s2;
    endcase
    case (unit_sel)
      SEL_ARITH: exec_res = arith_res;
      SEL_LOGIC: exec_res = logic_res;
      SEL_SHIFT: exec_res = shift_res;
      default:   exec_res = (op_i == OP_UPIMM) ? {hi_imm_i, {IMM_W{1'b0}}} : '0;
    endcase
    new_flags       = '0;
    new_flags[FL_N] = exec_res[W-1];
    new_flags[FL_Z] = (exec_res == '0);
    new_flags[FL_V] = (unit_sel == SEL_ARITH) & arith_v;
    new_flags[FL_C] = (unit_sel == SEL_ARITH) & arith_c;
  end

  assign ea_o = rs_i + s2;

  // Next-state
  always_comb begin
    fl_en = valid_i & setcc_i;
    dst_d = valid_i ? exec_res : dst_q;
    fl_d  = fl_en ? new_flags : fl_q;
    wbv_d = valid_i;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      dst_q <= '0;
      fl_q  <= '0;
      wbv_q <= 1'b0;
    end else begin
      dst_q <= dst_d;
      fl_q  <= fl_d;
      wbv_q <= wbv_d;
    end
  end

  assign result_o   = dst_q;
  assign flags_o    = fl_q;
  assign wb_valid_o = wbv_q;

  localparam int UNUSED_HI = HI_W;
endmodule

// File: rtl/exu_stage_chk.sv
module exu_stage_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic         setcc_i,
  input logic [W-1:0] result_o,
  input logic         wb_valid_o,
  input logic [3:0]   flags_o
);
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && setcc_i) |=> $stable(flags_o)); // R9
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && setcc_i) |=> (flags_o[2] == (result_o == '0))); // R8
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && setcc_i) |=> (flags_o[3] == result_o[W-1])); // R8
  AST_UPIMM_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd12) |=> (result_o[IMM_W-1:0] == '0)); // R6
  AST_LOGIC_VC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && setcc_i && op_i >= 4'd6) |=> (flags_o[1:0] == 2'b00)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && !wb_valid_o)); // R10
  AST_WB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> wb_valid_o); // R10
endmodule

bind exu_stage exu_stage_chk #(.W(W), .IMM_W(IMM_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_int),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .setcc_i    (setcc_i),
  .result_o   (result_o),
  .wb_valid_o (wb_valid_o),
  .flags_o    (flags_o)
);

// File: tb/test_exu_stage.sv
`timescale 1ns/1ps
module test_exu_stage;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [31:0] rs_i;
  logic [31:0] s2_reg_i;
  logic        imm_sel_i;
  logic [12:0] imm_i;
  logic [18:0] hi_imm_i;
  logic        setcc_i;
  logic [31:0] ea_o;
  logic [31:0] result_o;
  logic        wb_valid_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int failures = 0;
  logic [3:0]  exp_fl;
  logic [31:0] exp_res;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  exu_stage i_exu_stage (
    .clk_i, .rst_ni, .valid_i, .op_i, .rs_i, .s2_reg_i, .imm_sel_i,
    .imm_i, .hi_imm_i, .setcc_i, .ea_o, .result_o, .wb_valid_o, .flags_o
  );

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    if (op <= 4'd1) return "R1";
    if (op <= 4'd3) return "R2";
    if (op <= 4'd5) return "R3";
    if (op <= 4'd8) return "R4";
    if (op <= 4'd11) return "R5";
    return "R6";
  endfunction

  // Reference model: {result, N, Z, V, C}
  function automatic logic [35:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [18:0] hi,
                                        input logic cin);
    logic [32:0] wide;
    logic [31:0] x, y, r;
    logic        v, c;
    v = 1'b0; c = 1'b0; r = '0;
    x = (op == 4'd4 || op == 4'd5) ? b : a;
    y = (op == 4'd4 || op == 4'd5) ? a : b;
    case (op)
      4'd0, 4'd1: begin
        wide = {1'b0, x} + {1'b0, y} + ((op == 4'd1) ? {32'd0, cin} : 33'd0);
        r = wide[31:0]; c = wide[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end
      4'd2, 4'd3, 4'd4, 4'd5: begin
        wide = {1'b0, x} - {1'b0, y} - ((op == 4'd3 || op == 4'd5) ? {32'd0, cin} : 33'd0);
        r = wide[31:0]; c = wide[32];
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end
      4'd6: r = a & b;
      4'd7: r = a | b;
      4'd8: r = a ^ b;
      4'd9: r = a << b[4:0];
      4'd10: r = a >> b[4:0];
      4'd11: r = $signed(a) >>> b[4:0];
      4'd12: r = {hi, 13'd0};
      default: r = '0;
    endcase
    return {r, r[31], (r == 32'd0), v, c};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input bit isel, input logic [12:0] imm, input logic [18:0] hi,
                     input bit scc, input bit chk_ea);
    logic [31:0] s2;
    logic [35:0] m;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; rs_i = a; s2_reg_i = b; imm_sel_i = isel;
    imm_i = imm; hi_imm_i = hi; setcc_i = scc;
    s2 = isel ? {{19{imm[12]}}, imm} : b;
    m = model(op, a, s2, hi, exp_fl[0]);
    #1;
    if (chk_ea) check(ea_o == a + s2, "R11", "ea", ea_o, a + s2);
    @(posedge clk_i);
    #1;
    exp_res = m[35:4];
    if (scc) exp_fl = m[3:0];
    check(result_o == exp_res, op_tag(op), isel ? "result R7 imm" : "result", result_o, exp_res);
    check(flags_o == exp_fl, scc ? "R8" : "R9", "flags", {28'd0, flags_o}, {28'd0, exp_fl});
    check(wb_valid_o == 1'b1, "R10", "wb_valid", {31'd0, wb_valid_o}, 32'd1);
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0; setcc_i = 1'b1; rs_i = next_rand();
    @(posedge clk_i);
    #1;
    check(result_o == exp_res, "R10", "idle result", result_o, exp_res);
    check(flags_o == exp_fl, "R9", "idle flags", {28'd0, flags_o}, {28'd0, exp_fl});
    check(wb_valid_o == 1'b0, "R10", "idle wb_valid", {31'd0, wb_valid_o}, 32'd0);
  endtask

  logic [31:0] corner [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h0000_FFFF, 32'h1234_5678, 32'hFFFF_0000};

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; rs_i = '0; s2_reg_i = '0;
    imm_sel_i = 1'b0; imm_i = '0; hi_imm_i = '0; setcc_i = 1'b0;
    exp_fl = '0; exp_res = '0;
    repeat (3) @(posedge clk_i);
    #1;
    check(result_o == 32'd0, "R12", "reset result", result_o, 32'd0);
    check(flags_o == 4'd0, "R12", "reset flags", {28'd0, flags_o}, 32'd0);
    check(wb_valid_o == 1'b0, "R12", "reset wb_valid", {31'd0, wb_valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);

    // All operations over corner operand pairs (R1 to R6, R8)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(4'(op), corner[i], corner[j], 1'b0, 13'd0, next_rand() >> 13, 1'b1, (i == j));

    // Pseudo-random operands, flags toggled
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r0;
      r0 = next_rand();
      run(r0[3:0], next_rand(), next_rand(), 1'b0, 13'd0, r0[31:13], r0[4], 1'b1);
      if (r0[7:5] == 3'd0) idle();
    end

    // Shift amounts: all six low bits, register and immediate path (R5, R7)
    for (int op = 9; op < 12; op++)
      for (int amt = 0; amt < 64; amt++) begin
        run(4'(op), 32'hC35A_0F81, {26'h2AB_CDE, 6'(amt)}, 1'b0, 13'd0, 19'd0, 1'b1, 1'b0);
        run(4'(op), 32'h8765_4321, 32'd0, 1'b1, {7'h55, 6'(amt)}, 19'd0, 1'b1, 1'b1);
      end

    // Immediate sign extension around bit 12 (R7)
    for (int k = 0; k < 64; k++) begin
      logic [12:0] iv;
      iv = (k < 4) ? 13'(32'h0FFF + k) : 13'(next_rand());
      run(4'(k % 6), next_rand(), next_rand(), 1'b1, iv, 19'd0, 1'b1, 1'b1);
    end

    // Flags held when update flag is clear (R9)
    run(4'd2, 32'd0, 32'd1, 1'b0, 13'd0, 19'd0, 1'b1, 1'b0);
    for (int k = 0; k < 40; k++)
      run(4'(k % 13), next_rand(), corner[k % 8], 1'b0, 13'd0, 19'h7FFFF, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule